// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Unit

This unit gathers the seven event pulses raised by an I2C controller's bit engine and turns them into one interrupt line and a small register set for the processor. Every event pulse is captured in a sticky pending flag. A mask register chooses which pending flags may raise the interrupt. A status register shows a subset of the flags together with a live bus-busy indication. A vector register names the most urgent enabled event.

Software reacts to the interrupt by reading the vector register. The read returns a 3-bit code, and the same read retires the event that the code names. Events with a smaller code are more urgent. Repeated vector reads therefore drain the pending events in order until the register returns zero and the interrupt drops. Status bits that software handles itself can be cleared by writing ones to them.

Top module: `i2c_irq_vector`

## Requirements
- R1: After a synchronous reset, all pending flags and the mask are zero, `irq` is low, and `reg_rdata` is zero.
- R2: A one-cycle pulse on `ev_pulse[i]` sets pending flag i whether or not mask bit i is set. The event indices are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: The mask register is at address 0x04. Bits 6:0 are read/write and enable event index i at bit i. Bits 15:7 always read as zero.
- R4: The status register is at address 0x08. Bits 0, 1, 2 and 5 show pending flags 0, 1, 2 and 5. Bit 12 shows the `bus_busy` input as sampled at the read. All other bits read as zero.
- R5: A write to the status register clears each of the flags at bits 0, 1, 2 and 5 whose write bit is one, and leaves the rest alone. An event pulse arriving in the same cycle as the clear wins, and the flag stays set.
- R6: The vector register is at address 0x28. A read returns i+1 for the lowest index i whose flag is pending and whose mask bit is set: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as slave. It returns 0 when no enabled flag is pending.
- R7: A nonzero vector read clears only the pending flag it reports. All other flags keep their values.
- R8: A masked pending flag is never reported by the vector register and never raises `irq`. It is reported once its mask bit is set.
- R9: `irq` is high exactly when the vector register would read nonzero. It follows the registered flag and mask state in the same cycle that state changes.
- R10: Read data is returned in the cycle after the read strobe and is zero in every other cycle. Reads of unmapped addresses return zero. Writes to the vector register or to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 7 | Single-cycle event pulses, one bit per event index |
| bus_busy | input | 1 | Live bus-busy level, shown in the status register |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read, valid while `reg_en` is high |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse, a mask write and a status or vector access all take effect on the clock edge that samples them. `irq` reflects the new state straight after that edge, and read data appears on `reg_rdata` straight after the edge that took the read strobe. The bench drives every input on the falling edge. It runs a behavioural model of the flags, the mask and the read register on the rising edge, and compares `irq` and `reg_rdata` with that model on every falling edge, half a cycle after each result has settled. Directed reads check the code sequences, the clear-versus-set race and the masking cases against values worked out by hand.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int EV_N   = 7;
    localparam int REG_W  = 16;
    localparam int ADR_W  = 8;
    localparam int CODE_W = $clog2(EV_N + 1);
    localparam int BUSY_POS = 12;

    localparam logic [ADR_W-1:0] OFS_MASK = 8'h04;
    localparam logic [ADR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADR_W-1:0] OFS_VEC  = 8'h28;

    typedef logic [EV_N-1:0]  ev_vec_t;
    typedef logic [REG_W-1:0] word_t;

    // Event flags that are visible (and clearable) in the status word,
    // each at the bit position equal to its event index.
    localparam ev_vec_t STAT_VISIBLE = 7'b010_0111;

    typedef enum logic [CODE_W-1:0] {
        VEC_NONE = 3'd0,
        VEC_ARB  = 3'd1,
        VEC_NAK  = 3'd2,
        VEC_ACC  = 3'd3,
        VEC_RXR  = 3'd4,
        VEC_TXR  = 3'd5,
        VEC_STOP = 3'd6,
        VEC_SLV  = 3'd7
    } vec_code_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_STAT,
        SEL_VEC
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } reg_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MASK: s = SEL_MASK;
            OFS_STAT: s = SEL_STAT;
            OFS_VEC:  s = SEL_VEC;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic word_t build_status(input ev_vec_t pend, input logic busy);
        word_t w;
        w = '0;
        for (int i = 0; i < EV_N; i++) begin
            if (STAT_VISIBLE[i]) w[i] = pend[i];
        end
        w[BUSY_POS] = busy;
        return w;
    endfunction

    function automatic ev_vec_t status_clears(input word_t w);
        ev_vec_t c;
        for (int i = 0; i < EV_N; i++) begin
            c[i] = STAT_VISIBLE[i] & w[i];
        end
        return c;
    endfunction

    function automatic ev_vec_t code_to_onehot(input logic [CODE_W-1:0] c);
        ev_vec_t oh;
        oh = '0;
        for (int i = 0; i < EV_N; i++) begin
            if (c == CODE_W'(i + 1)) oh[i] = 1'b1;
        end
        return oh;
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_set,
    input  logic [N-1:0] clr_w1c,
    input  logic [N-1:0] clr_ack,
    output logic [N-1:0] pend
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    pend[gi] <= 1'b0;
                else if (ev_set[gi])
                    pend[gi] <= 1'b1;
                else if (clr_w1c[gi] || clr_ack[gi])
                    pend[gi] <= 1'b0;
            end

            // R2: an event pulse always leaves its flag set
            p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
                ev_set[gi] |=> pend[gi]);

            // R5: a clear with no competing pulse empties the flag
            p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
                (clr_w1c[gi] && !ev_set[gi]) |=> !pend[gi]);
        end
    endgenerate

    // R7: a vector read retires at most one event
    p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_ack));

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 7,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  enable,
    output logic [CW-1:0] code,
    output logic          any
);

    logic [N-1:0] act;
    logic [N:0]   seen;
    logic [N-1:0] first;

    assign act     = pend & enable;
    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_chain
            assign seen[gi+1] = seen[gi] | act[gi];
            assign first[gi]  = act[gi] & ~seen[gi];
        end
    endgenerate

    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) code = CW'(i + 1);
        end
    end

    assign any = seen[N];

endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [ADR_W-1:0]  reg_addr,
    input  word_t             reg_wdata,
    input  ev_vec_t           pend,
    input  logic [CODE_W-1:0] vec_code,
    input  logic              bus_busy,
    output ev_vec_t           mask,
    output ev_vec_t           clr_w1c,
    output ev_vec_t           clr_ack,
    output word_t             reg_rdata
);

    reg_req_t req;
    word_t    rd_val;

    always_comb begin
        req.rd  = reg_en & ~reg_wr;
        req.wr  = reg_en & reg_wr;
        req.sel = decode_addr(reg_addr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (req.wr && req.sel == SEL_MASK)
            mask <= reg_wdata[EV_N-1:0];
    end

    assign clr_w1c = (req.wr && req.sel == SEL_STAT) ? status_clears(reg_wdata) : '0;
    assign clr_ack = (req.rd && req.sel == SEL_VEC)  ? code_to_onehot(vec_code) : '0;

    always_comb begin
        case (req.sel)
            SEL_MASK: rd_val = word_t'(mask);
            SEL_STAT: rd_val = build_status(pend, bus_busy);
            SEL_VEC:  rd_val = word_t'(vec_code);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (req.rd)
            reg_rdata <= rd_val;
        else
            reg_rdata <= '0;
    end

    // R3: the mask only moves on a write to its own address
    p_mask_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && reg_wr && reg_addr == OFS_MASK) |=> $stable(mask));

    // R10: no read strobe, no read data
    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_en && !reg_wr) |=> (reg_rdata == '0));

    // R3: unused mask bits read as zero
    p_mask_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_addr == OFS_MASK) |=> (reg_rdata[REG_W-1:EV_N] == '0));

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
    import i2c_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  ev_pulse,
    input  logic        bus_busy,
    input  logic        reg_en,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq
);

    ev_vec_t           pend;
    ev_vec_t           mask;
    ev_vec_t           clr_w1c;
    ev_vec_t           clr_ack;
    logic [CODE_W-1:0] vec_code;
    logic              vec_any;

    irq_event_latch #(.N(EV_N)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .ev_set  (ev_pulse),
        .clr_w1c (clr_w1c),
        .clr_ack (clr_ack),
        .pend    (pend)
    );

    irq_prio_enc #(.N(EV_N), .CW(CODE_W)) u_prio (
        .pend   (pend),
        .enable (mask),
        .code   (vec_code),
        .any    (vec_any)
    );

    irq_reg_if u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend      (pend),
        .vec_code  (vec_code),
        .bus_busy  (bus_busy),
        .mask      (mask),
        .clr_w1c   (clr_w1c),
        .clr_ack   (clr_ack),
        .reg_rdata (reg_rdata)
    );

    assign irq = vec_any;

    // R9: interrupt agrees with the vector code
    p_irq_matches_r9: assert property (@(posedge clk) disable iff (rst)
        irq == (vec_code != '0));

    // R8: a reported code always names an enabled, pending event
    p_code_enabled_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_code != '0) |-> (mask[vec_code - 1'b1] && pend[vec_code - 1'b1]));

    // R6: nothing more urgent is enabled and pending than the code reported
    p_code_lowest_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_code != '0) |->
            ((pend & mask & ((ev_vec_t'(1) << (vec_code - 1'b1)) - ev_vec_t'(1))) == '0));

    // R7: a vector read retires the reported event unless it re-fires at once
    p_ack_retires_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_en && !reg_wr && reg_addr == OFS_VEC && vec_code != '0
            && !ev_pulse[vec_code - 1'b1])
        |=> !pend[$past(vec_code) - 1'b1]);

endmodule

// File: tb/sim_i2c_irq_vector.sv
module sim_i2c_irq_vector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  ev_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_irq_vector u0 (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
        .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    logic [6:0]  m_pend  = '0;
    logic [6:0]  m_mask  = '0;
    logic [15:0] m_rdata = '0;

    function automatic int model_code(input logic [6:0] p, input logic [6:0] m);
        for (int i = 0; i < 7; i++)
            if (p[i] && m[i]) return i + 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        logic [6:0] nxt;
        int v;
        if (rst) begin
            m_pend = '0; m_mask = '0; m_rdata = '0;
        end else begin
            nxt = m_pend;
            m_rdata = '0;
            if (reg_en && !reg_wr) begin
                case (reg_addr)
                    8'h04: m_rdata = {9'd0, m_mask};
                    8'h08: m_rdata = {3'd0, bus_busy, 6'd0, m_pend[5], 2'd0, m_pend[2:0]};
                    8'h28: begin
                        v = model_code(m_pend, m_mask);
                        m_rdata = 16'(v);
                        if (v != 0) nxt[v-1] = 1'b0;
                    end
                    default: m_rdata = '0;
                endcase
            end
            if (reg_en && reg_wr && reg_addr == 8'h08) begin
                if (reg_wdata[0]) nxt[0] = 1'b0;
                if (reg_wdata[1]) nxt[1] = 1'b0;
                if (reg_wdata[2]) nxt[2] = 1'b0;
                if (reg_wdata[5]) nxt[5] = 1'b0;
            end
            if (reg_en && reg_wr && reg_addr == 8'h04) m_mask = reg_wdata[6:0];
            m_pend = nxt | ev_pulse;
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (irq !== (model_code(m_pend, m_mask) != 0)) begin
                n_fails++;
                $display("FAIL R9 irq at %0t: actual %b expected %b", $time, irq,
                         model_code(m_pend, m_mask) != 0);
            end
            n_checks++;
            if (reg_rdata !== m_rdata) begin
                n_fails++;
                $display("FAIL R10 rdata at %0t: actual %h expected %h", $time, reg_rdata, m_rdata);
            end
        end
    end

    task automatic check16(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] w);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = w;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        ev_pulse = e;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check16({15'd0, irq}, 16'h0000, "R1 irq after reset");
        check16(reg_rdata, 16'h0000, "R1 rdata after reset");
        do_read(8'h28, d); check16(d, 16'h0000, "R1 vector after reset");
        do_read(8'h04, d); check16(d, 16'h0000, "R1 mask after reset");
        do_read(8'h08, d); check16(d, 16'h0000, "R1 status after reset");

        // R3: mask width
        do_write(8'h04, 16'hFFFF);
        do_read(8'h04, d); check16(d, 16'h007F, "R3 mask readback");
        do_write(8'h04, 16'h0000);

        // R2, R8: masked event still latches but is not reported
        pulse(7'b000_0010);
        check16({15'd0, irq}, 16'h0000, "R8 irq while masked");
        do_read(8'h08, d); check16(d, 16'h0002, "R2 status shows masked NACK");
        do_read(8'h28, d); check16(d, 16'h0000, "R8 vector while masked");
        do_read(8'h08, d); check16(d, 16'h0002, "R8 masked flag kept");

        // R8, R9, R7: unmask then acknowledge
        do_write(8'h04, 16'h0002);
        check16({15'd0, irq}, 16'h0001, "R9 irq after unmask");
        do_read(8'h28, d); check16(d, 16'h0002, "R8 vector after unmask");
        check16({15'd0, irq}, 16'h0000, "R9 irq after ack");
        do_read(8'h08, d); check16(d, 16'h0000, "R7 status after ack");

        // R4, R5: busy bit and write-one-to-clear
        bus_busy = 1'b1;
        do_write(8'h04, 16'h0000);
        pulse(7'b110_0001);
        do_read(8'h08, d); check16(d, 16'h1021, "R4 status with busy");
        do_write(8'h08, 16'h0001);
        do_read(8'h08, d); check16(d, 16'h1020, "R5 w1c clears bit 0");
        do_write(8'h08, 16'h0000);
        do_read(8'h08, d); check16(d, 16'h1020, "R5 zero write keeps");

        // R6, R7: ordered draining
        pulse(7'b001_1000);
        do_write(8'h04, 16'h007F);
        do_read(8'h28, d); check16(d, 16'h0004, "R6 first code");
        do_read(8'h08, d); check16(d, 16'h1020, "R7 others remain");
        do_read(8'h28, d); check16(d, 16'h0005, "R6 second code");
        do_read(8'h28, d); check16(d, 16'h0006, "R6 third code");
        do_read(8'h28, d); check16(d, 16'h0007, "R6 fourth code");
        do_read(8'h28, d); check16(d, 16'h0000, "R6 drained");

        // R5: pulse wins over a same-cycle clear
        @(negedge clk);
        ev_pulse = 7'b000_0100;
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 8'h08; reg_wdata = 16'h0004;
        @(negedge clk);
        ev_pulse = '0; reg_en = 1'b0; reg_wr = 1'b0;
        do_read(8'h08, d); check16(d, 16'h1004, "R5 set wins race");
        do_write(8'h08, 16'h0004);
        do_read(8'h08, d); check16(d, 16'h1000, "R5 later clear");
        bus_busy = 1'b0;

        // R10: unmapped and vector writes
        pulse(7'b000_0001);
        do_read(8'h00, d); check16(d, 16'h0000, "R10 unmapped read");
        do_write(8'h28, 16'hFFFF);
        do_write(8'h3C, 16'hFFFF);
        do_read(8'h04, d); check16(d, 16'h007F, "R10 mask untouched");
        do_read(8'h28, d); check16(d, 16'h0001, "R10 vector write ignored");
        do_read(8'h28, d); check16(d, 16'h0000, "R7 vector empty");

        // R6: all events at once report in code order
        pulse(7'b111_1111);
        for (int k = 1; k <= 7; k++) begin
            do_read(8'h28, d);
            check16(d, 16'(k), "R6 full order");
        end
        check16({15'd0, irq}, 16'h0000, "R9 irq low when drained");

        repeat (2) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

endmodule